// File: doc/BRIEF.md
# External Status Interrupt Latch Unit

This block watches six status conditions of a serial communication controller and presents them to a host as one readable status word together with an interrupt-pending flag. The six conditions are break/abort, transmit underrun/end-of-message, clear-to-send, carrier detect, sync/hunt and baud counter zero count. Each condition has its own enable bit, and one master enable gates the interrupt output. While the latches are open, the status word tracks the conditions as they are. When an enabled condition makes a qualifying transition, the latches close. The enabled latchable bits then hold a snapshot until the host issues a reset-status command.

Each condition has its own closing rule. Break/abort closes on either edge and also refreshes its own snapshot bit while the latches are already closed, so a short break is never lost. Underrun and zero count close only when they become set. Clear-to-send, carrier detect and sync/hunt close on either edge. For clear-to-send and carrier detect, the reset command leaves the latches closed when an odd number of edges arrived on an enabled one of them while the latches were closed. Zero count is never held in the snapshot. It is forced to 0 while its enable bit is clear. Sync/hunt is forced to 0 and cannot close the latches when asynchronous mode runs with the crystal-oscillator option.

The host reads with an active-low read strobe. The status word is frozen from the falling edge of the strobe until after its rising edge. All raw conditions and the strobe pass through synchronizers before edge detection. The enables, mode bits and reset command are taken as already synchronous.

Top module: `ext_status_latch`

## Requirements
- R1: After synchronous reset with all conditions low, `status` is 0 and `irq_pend` is 0.
- R2: Status bit positions are 0 break/abort, 1 underrun, 2 clear-to-send, 3 carrier detect, 4 sync/hunt, 5 zero count; `src_en` uses the same positions. While the latches are open, and for any source whose enable bit is clear, the status bit shows the synchronized live condition.
- R3: The latches close only on a qualifying transition of an enabled source. While they are closed, enabled latchable bits hold their snapshot. `irq_pend` is high exactly while the latches are closed and `master_en` is 1.
- R4: Break/abort closes the latches on either edge. While the latches are closed, a break/abort edge loads its new value into its snapshot bit and leaves the latches closed.
- R5: Underrun closes the latches on its rising edge only; its falling edge does not close them.
- R6: Clear-to-send and carrier detect close on either edge. At a reset-status command, the latches stay closed (snapshot reloaded from live) if an odd number of edges occurred, on an enabled one of these inputs, while the latches were closed. With an even count they reopen.
- R7: Zero count always shows live status, reads 0 while its enable bit is clear, and closes the latches only on its rising edge.
- R8: Sync/hunt closes on either edge. While `async_mode` and `xtal_en` are both 1 it reads 0 and does not close the latches.
- R9: While the synchronized `rd_n` is low, `status` does not change; it resumes tracking after `rd_n` returns high.
- R10: A reset-status command with no odd edge count opens the latches, clears `irq_pend` and reloads the snapshot from live conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_raw | input | 6 | Raw condition inputs, asynchronous, bit order as in R2 |
| src_en | input | 6 | Per-source enable, bit order as in R2 |
| master_en | input | 1 | Master enable for the interrupt-pending output |
| async_mode | input | 1 | Asynchronous mode selected |
| xtal_en | input | 1 | Crystal-oscillator option enabled |
| rd_n | input | 1 | Active-low read strobe, asynchronous |
| rst_cmd | input | 1 | One-cycle reset-status command |
| status | output | 6 | Status word seen by the host |
| irq_pend | output | 1 | Status interrupt pending |

## Verification
The bench aims at the closing rule of each source. Underrun and zero count fall while the latches are open; a design that treated every edge alike would set the interrupt there. Clear-to-send gets one edge and carrier detect gets two while the latches are closed, and a reset command follows each case. A design without parity tracking would reopen after the single edge or stay stuck after the pair. Break/abort toggles while closed, zero count is disabled and then falls while closed, sync/hunt is forced off by the crystal option, and a disabled input changes in the middle of a read. Wrong handling would show up as a stale break bit, a stale or nonzero zero-count bit, a spurious interrupt, or a status word that moves during the read strobe.

// File: rtl/esl_pkg.sv
// Package: shared constants for the external status latch unit.
// Assumes six sources in a fixed bit order that the host decodes.
package esl_pkg;
    localparam int NSRC      = 6;
    localparam int BRK_IDX   = 0;
    localparam int UNDR_IDX  = 1;
    localparam int CTS_IDX   = 2;
    localparam int DCD_IDX   = 3;
    localparam int SYNC_IDX  = 4;
    localparam int ZC_IDX    = 5;
    localparam int SYNC_STAGES_DEF = 2;
    // sources that close only on a rising edge
    localparam logic [NSRC-1:0] RISE_ONLY_MASK = NSRC'((1 << UNDR_IDX) | (1 << ZC_IDX));
    // sources whose edge count parity decides reopening
    localparam logic [NSRC-1:0] PARITY_MASK    = NSRC'((1 << CTS_IDX) | (1 << DCD_IDX));
    // sources held in the snapshot when closed
    localparam logic [NSRC-1:0] LATCH_MASK     = ~NSRC'(1 << ZC_IDX);
endpackage

// File: rtl/esl_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is promised.
module esl_sync #(
    parameter int   W       = 1,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] RST_VEC = {W{RST_VAL}};

    logic [W-1:0] stg [STAGES];

    // shift the input through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VEC;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/esl_src_qual.sv
// Module: derives effective live values and qualified closing events
// for each source. Assumes synchronized inputs and quasi-static modes.
module esl_src_qual
    import esl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] syn,
    input  logic [NSRC-1:0] en,
    input  logic            async_mode,
    input  logic            xtal_en,
    output logic [NSRC-1:0] live,
    output logic [NSRC-1:0] chg,
    output logic [NSRC-1:0] qual
);
    logic            force_sync;
    logic [NSRC-1:0] live_q;
    logic [NSRC-1:0] rise;
    logic [NSRC-1:0] edge_sel;

    assign force_sync = async_mode & xtal_en;

    // apply per-source forcing rules to the synchronized inputs
    always_comb begin
        live           = syn;
        live[ZC_IDX]   = syn[ZC_IDX] & en[ZC_IDX];
        live[SYNC_IDX] = syn[SYNC_IDX] & ~force_sync;
    end

    // remember last cycle's live values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= '0;
        else        live_q <= live;
    end

    assign chg  = live ^ live_q;
    assign rise = live & ~live_q;

    // pick the closing edge rule per source
    always_comb begin
        edge_sel = (chg & ~RISE_ONLY_MASK) | (rise & RISE_ONLY_MASK);
        edge_sel[SYNC_IDX] = edge_sel[SYNC_IDX] & ~force_sync;
        qual = edge_sel & en;
    end
endmodule

// File: rtl/esl_latch_core.sv
// Module: latch state machine. Holds the closed flag, the snapshot and
// the per-input edge parity, and forms the host-visible status view.
// Assumes rst_cmd is a single-cycle synchronous pulse.
module esl_latch_core
    import esl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_cmd,
    input  logic [NSRC-1:0] en,
    input  logic [NSRC-1:0] live,
    input  logic [NSRC-1:0] chg,
    input  logic [NSRC-1:0] qual,
    output logic [NSRC-1:0] view,
    output logic            closed
);
    logic [NSRC-1:0] snap;
    logic [NSRC-1:0] par;
    logic            close_evt;
    logic            keep_closed;

    assign close_evt   = |qual;
    assign keep_closed = closed & (|(par & en & PARITY_MASK));

    // update closed flag, snapshot and edge parity
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            closed <= 1'b0;
            snap   <= '0;
            par    <= '0;
        end else if (rst_cmd) begin
            par    <= '0;
            snap   <= live;
            closed <= keep_closed | close_evt;
        end else if (!closed) begin
            snap   <= live;
            closed <= close_evt;
        end else begin
            par <= par ^ (chg & PARITY_MASK);
            if (qual[BRK_IDX]) snap[BRK_IDX] <= live[BRK_IDX];
        end
    end

    // per-bit select between held snapshot and live value
    for (genvar i = 0; i < NSRC; i++) begin : g_view
        assign view[i] = (closed && en[i] && LATCH_MASK[i]) ? snap[i] : live[i];
    end

    // R3
    no_spurious_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!closed && !rst_cmd && !close_evt) |=> !closed);

    // R4
    brk_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (closed && !rst_cmd && qual[BRK_IDX]) |=> (closed && snap[BRK_IDX] == $past(live[BRK_IDX])));

    // R6
    odd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_cmd && closed && ((par & en & PARITY_MASK) != '0)) |=> closed);

    // R10
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_cmd && ((par & en & PARITY_MASK) == '0) && !close_evt) |=> !closed);
endmodule

// File: rtl/ext_status_latch.sv
// Module: top of the external status latch unit. Synchronizes the raw
// conditions and read strobe, and freezes the status word during reads.
// Assumes src_en, master_en and mode bits are written synchronously.
module ext_status_latch
    import esl_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_raw,
    input  logic [NSRC-1:0] src_en,
    input  logic            master_en,
    input  logic            async_mode,
    input  logic            xtal_en,
    input  logic            rd_n,
    input  logic            rst_cmd,
    output logic [NSRC-1:0] status,
    output logic            irq_pend
);
    logic [NSRC-1:0] syn;
    logic            rd_s;
    logic            rd_low;
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] chg;
    logic [NSRC-1:0] qual;
    logic [NSRC-1:0] view;
    logic            closed;
    logic [NSRC-1:0] stat_q;

    esl_sync #(.W(NSRC), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d(src_raw), .q(syn)
    );

    esl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .d(rd_n), .q(rd_s)
    );

    esl_src_qual u_qual (
        .clk(clk), .rst_n(rst_n), .syn(syn), .en(src_en),
        .async_mode(async_mode), .xtal_en(xtal_en),
        .live(live), .chg(chg), .qual(qual)
    );

    esl_latch_core u_core (
        .clk(clk), .rst_n(rst_n), .rst_cmd(rst_cmd), .en(src_en),
        .live(live), .chg(chg), .qual(qual), .view(view), .closed(closed)
    );

    assign rd_low = ~rd_s;

    // refresh the host status word except while a read is active
    always_ff @(posedge clk) begin
        if (!rst_n)      stat_q <= '0;
        else if (!rd_low) stat_q <= view;
    end

    assign status   = stat_q;
    assign irq_pend = closed & master_en;

    // R9
    read_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_low |=> $stable(status));

    // R3
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pend && !rst_cmd) |=> (irq_pend || !master_en));
endmodule

// File: tb/ext_status_latch_bench.sv
// Bench: scoreboard-style check of the external status latch unit.
module ext_status_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] src_raw = '0;
    logic [5:0] src_en = 6'b111111;
    logic       master_en = 1'b1;
    logic       async_mode = 1'b0;
    logic       xtal_en = 1'b0;
    logic       rd_n = 1'b1;
    logic       rst_cmd = 1'b0;
    logic [5:0] status;
    logic       irq_pend;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [5:0] st;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    ext_status_latch u_ext_status_latch (
        .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .src_en(src_en),
        .master_en(master_en), .async_mode(async_mode), .xtal_en(xtal_en),
        .rd_n(rd_n), .rst_cmd(rst_cmd), .status(status), .irq_pend(irq_pend)
    );

    // monitor: pop expected items and compare with outputs
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (status !== e.st || irq_pend !== e.irq) begin
                    errors++;
                    $display("FAIL %s: status=%b irq=%b expected status=%b irq=%b",
                             e.tag, status, irq_pend, e.st, e.irq);
                end
            end
        end
    end

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    // driver: push an expected item and wake the monitor
    task automatic expect_now(input logic [5:0] st, input logic irq, input string tag);
        exp_t e;
        e.st = st; e.irq = irq; e.tag = tag;
        exp_q.push_back(e);
        -> chk_ev;
        #1;
    endtask

    task automatic set_bit(input int idx, input logic v);
        @(negedge clk);
        src_raw[idx] = v;
        settle();
    endtask

    task automatic pulse_rst_cmd();
        @(negedge clk);
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        expect_now(6'b000000, 1'b0, "R1 reset state");

        set_bit(0, 1'b1);
        expect_now(6'b000001, 1'b1, "R4 break rise closes");
        set_bit(2, 1'b1);
        expect_now(6'b000001, 1'b1, "R3 cts held while closed");
        set_bit(0, 1'b0);
        expect_now(6'b000000, 1'b1, "R4 break fall refreshes while closed");
        pulse_rst_cmd();
        expect_now(6'b000100, 1'b1, "R6 odd cts edges keep closed");
        pulse_rst_cmd();
        expect_now(6'b000100, 1'b0, "R10 reset command reopens");

        set_bit(1, 1'b1);
        expect_now(6'b000110, 1'b1, "R5 underrun rise closes");
        pulse_rst_cmd();
        expect_now(6'b000110, 1'b0, "R10 reopen after underrun");
        set_bit(1, 1'b0);
        expect_now(6'b000100, 1'b0, "R5 underrun fall no close");

        set_bit(3, 1'b1);
        expect_now(6'b001100, 1'b1, "R6 dcd rise closes");
        set_bit(3, 1'b0);
        expect_now(6'b001100, 1'b1, "R3 dcd held while closed");
        set_bit(3, 1'b1);
        pulse_rst_cmd();
        expect_now(6'b001100, 1'b0, "R6 even dcd edges reopen");

        @(negedge clk); src_en = 6'b011111;
        set_bit(5, 1'b1);
        expect_now(6'b001100, 1'b0, "R7 zero count forced 0 when disabled");
        @(negedge clk); src_en = 6'b111111;
        settle();
        expect_now(6'b101100, 1'b1, "R7 zero count rise closes");
        set_bit(5, 1'b0);
        expect_now(6'b001100, 1'b1, "R7 zero count live while closed");
        pulse_rst_cmd();
        set_bit(5, 1'b1);
        pulse_rst_cmd();
        expect_now(6'b101100, 1'b0, "R10 reopen after zero count");
        set_bit(5, 1'b0);
        expect_now(6'b001100, 1'b0, "R7 zero count fall no close");

        set_bit(4, 1'b1);
        expect_now(6'b011100, 1'b1, "R8 sync rise closes");
        pulse_rst_cmd();
        @(negedge clk); async_mode = 1'b1; xtal_en = 1'b1;
        settle();
        expect_now(6'b001100, 1'b0, "R8 sync forced 0 by crystal option");
        set_bit(4, 1'b0);
        expect_now(6'b001100, 1'b0, "R8 forced sync edge no close");
        @(negedge clk); async_mode = 1'b0; xtal_en = 1'b0;
        settle();

        @(negedge clk); src_en = 6'b110111;
        set_bit(3, 1'b0);
        expect_now(6'b000100, 1'b0, "R2 disabled dcd shows live");

        @(negedge clk); master_en = 1'b0;
        set_bit(1, 1'b1);
        expect_now(6'b000110, 1'b0, "R3 irq masked by master enable");
        @(negedge clk); master_en = 1'b1;
        settle();
        expect_now(6'b000110, 1'b1, "R3 irq shown after master enable");
        pulse_rst_cmd();
        expect_now(6'b000110, 1'b0, "R10 reopen before read test");

        @(negedge clk); rd_n = 1'b0;
        settle();
        set_bit(3, 1'b1);
        expect_now(6'b000110, 1'b0, "R9 status frozen during read");
        @(negedge clk); rd_n = 1'b1;
        settle();
        expect_now(6'b001110, 1'b0, "R9 status resumes after read");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule